// File: doc/BRIEF.md
# Dual FIFO Status Register

This block sits between a serial engine and a simple register bus. It holds two first-in first-out queues: a transmit queue that the bus fills and the engine drains, and a receive queue that the engine fills and the bus drains. One 32-bit status word shows the state of both queues. It also passes through the engine's interrupt line and holds two sticky error flags.

The bus has two addresses. A write to the data address pushes into the transmit queue, and a read from it pops the receive queue. A read of the status address returns the status word with no side effect. A write to the status address clears error flags: each flag is cleared by writing 1 to its bit. The engine pops transmit data with a request strobe and pushes receive data with a push strobe. Status reads are combinational, so they reflect the queue state of the current cycle.

Top module: `fifo_pair_status`

## Requirements
- R1: Status bit 0 (transmit error) becomes 1 in the cycle after either of two events: a bus write to the data address while the transmit queue holds DEPTH entries, or an engine transmit request while the transmit queue is empty.
- R2: Status bit 1 (receive error) becomes 1 in the cycle after an engine receive push while the receive queue holds DEPTH entries.
- R3: Writing to the status address (bus_addr = 1) with wdata bit 0 or bit 1 set to 1 clears the matching error flag. Writing 0 to a bit leaves that flag unchanged. If a clear and a new error event fall in the same cycle, the flag stays set.
- R4: Status bit 3 equals the eng_irq input in the same cycle.
- R5: Status bit 4 is 1 when the transmit queue is empty. Status bit 5 is 1 when the transmit queue holds fewer than DEPTH entries.
- R6: Status bit 6 is 1 when the receive queue holds at least one entry. Status bit 7 is 1 when the receive queue holds DEPTH entries.
- R7: Status bits 12:8 give the transmit occupancy and bits 20:16 give the receive occupancy, from 0 to DEPTH (16 by default). Bit 2, bits 15:13 and bits 31:21 read 0.
- R8: After a synchronous active-low reset, the status word reads 0x0000_0030, both queues are empty, and both error flags are 0.
- R9: Each queue delivers entries in the order they were written. A push into a full queue is dropped and leaves the stored entries intact. eng_tx_valid is 0 while the transmit queue is empty.
- R10: A bus read of the data address (bus_addr = 0) returns the receive head and pops it, or returns 0 when the receive queue is empty. bus_ack is 1 in every cycle with a bus read or write, including a write that overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_addr | input | 1 | 0 = data, 1 = status |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data (combinational) |
| bus_ack | output | 1 | Bus access acknowledge |
| eng_tx_req | input | 1 | Engine pops the transmit head |
| eng_tx_data | output | DATA_W | Transmit head entry |
| eng_tx_valid | output | 1 | Transmit head is valid |
| eng_rx_push | input | 1 | Engine pushes a received entry |
| eng_rx_data | input | DATA_W | Received entry |
| eng_irq | input | 1 | Engine interrupt line |

## Verification
The bench fills each queue to exactly DEPTH entries and then pushes once more. A design that wrapped a pointer there would overwrite the oldest entry, and one that failed to flag the event would leave the error bit clear; the drain that follows checks the order and contents of every entry. It also pops the empty transmit queue, which catches a transmit error flag that tracks only overflow and not underflow. It writes 0 to the status address and, separately, makes a clear and a new overflow land in the same cycle; a design that gives the clear priority drops the second event. Reads of the empty receive queue and an assertion of the interrupt line check that nothing stale leaks onto the bus.

// File: rtl/fps_pkg.sv
// Package: shared bit positions and field widths of the status word.
// Assumes a 32-bit bus and occupancy fields of five bits.
package fps_pkg;
    localparam int STAT_W     = 32;
    localparam int LVL_W      = 5;
    localparam int B_TX_ERR   = 0;
    localparam int B_RX_ERR   = 1;
    localparam int B_IRQ      = 3;
    localparam int B_TX_EMPTY = 4;
    localparam int B_TX_NFULL = 5;
    localparam int B_RX_NEMPT = 6;
    localparam int B_RX_FULL  = 7;
    localparam int TX_LVL_LSB = 8;
    localparam int RX_LVL_LSB = 16;
    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/fps_queue.sv
// Module: synchronous queue with an occupancy counter.
// Assumes DEPTH is a power of two. A push while full is dropped,
// a pop while empty does nothing. Both are reported as strobes.
module fps_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [DATA_W-1:0]           push_data,
    input  logic                        pop,
    output logic [DATA_W-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0]  level,
    output logic                        empty,
    output logic                        full,
    output logic                        overflow,
    output logic                        underflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              push_ok;
    logic              pop_ok;

    // Accepted transfers and the error strobes for refused ones.
    always_comb begin
        empty     = (count == '0);
        full      = (count == CNT_W'(DEPTH));
        push_ok   = push && !full;
        pop_ok    = pop && !empty;
        overflow  = push && full;
        underflow = pop && empty;
    end

    // Store accepted entries; the storage itself needs no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign level = count;
endmodule

// File: rtl/fps_sticky.sv
// Module: sticky error flag cleared by a write of 1.
// Assumes that a set and a clear in the same cycle leave the flag set.
module fps_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/fifo_pair_status.sv
// Module: transmit and receive queues with a combined status word.
// Assumes one bus access per cycle and a single-bit address
// (0 data, 1 status). Status reads have no side effects.
module fifo_pair_status #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic              bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ack,
    input  logic              eng_tx_req,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_valid,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_irq
);
    import fps_pkg::*;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic              wr_data, rd_data, wr_stat;
    logic [CNT_W-1:0]  tx_level, rx_level;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              tx_ovf, tx_unf, rx_ovf, rx_unf;
    logic [DATA_W-1:0] rx_head;
    logic              err_tx, err_rx;
    logic [STAT_W-1:0] status;

    // Decode the bus access.
    always_comb begin
        wr_data = bus_wr_en && (bus_addr == ADDR_DATA);
        rd_data = bus_rd_en && (bus_addr == ADDR_DATA);
        wr_stat = bus_wr_en && (bus_addr == ADDR_STAT);
    end

    fps_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_data), .push_data(bus_wdata[DATA_W-1:0]),
        .pop(eng_tx_req), .head(eng_tx_data), .level(tx_level),
        .empty(tx_empty), .full(tx_full),
        .overflow(tx_ovf), .underflow(tx_unf)
    );

    fps_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rd_data), .head(rx_head), .level(rx_level),
        .empty(rx_empty), .full(rx_full),
        .overflow(rx_ovf), .underflow(rx_unf)
    );

    fps_sticky u_txerr (
        .clk(clk), .rst_n(rst_n), .set(tx_ovf || tx_unf),
        .clr(wr_stat && bus_wdata[B_TX_ERR]), .flag(err_tx)
    );

    fps_sticky u_rxerr (
        .clk(clk), .rst_n(rst_n), .set(rx_ovf),
        .clr(wr_stat && bus_wdata[B_RX_ERR]), .flag(err_rx)
    );

    // Assemble the status word; unused bits are zero.
    always_comb begin
        status             = '0;
        status[B_TX_ERR]   = err_tx;
        status[B_RX_ERR]   = err_rx;
        status[B_IRQ]      = eng_irq;
        status[B_TX_EMPTY] = tx_empty;
        status[B_TX_NFULL] = !tx_full;
        status[B_RX_NEMPT] = !rx_empty;
        status[B_RX_FULL]  = rx_full;
        status[TX_LVL_LSB +: LVL_W] = LVL_W'(tx_level);
        status[RX_LVL_LSB +: LVL_W] = LVL_W'(rx_level);
    end

    // Read mux: status, receive head, or zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd_en && bus_addr == ADDR_STAT)
            bus_rdata = status;
        else if (rd_data && !rx_empty)
            bus_rdata = 32'(rx_head);
    end

    assign bus_ack      = bus_wr_en || bus_rd_en;
    assign eng_tx_valid = !tx_empty;
endmodule

// File: rtl/fps_checker.sv
// Module: property checker for fifo_pair_status, attached by bind.
// Observes the ports plus the queue levels and error flags.
module fps_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr_en,
    input logic             bus_rd_en,
    input logic             bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             bus_ack,
    input logic             eng_tx_req,
    input logic             eng_tx_valid,
    input logic             eng_rx_push,
    input logic [CNT_W-1:0] tx_level,
    input logic [CNT_W-1:0] rx_level,
    input logic             err_tx,
    input logic             err_rx
);
    assert_tx_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && !bus_addr && tx_level == CNT_W'(DEPTH)) |=> err_tx);
    assert_tx_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_req && tx_level == '0) |=> err_tx);
    assert_rx_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_level == CNT_W'(DEPTH)) |=> err_rx);
    assert_tx_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_tx && !(bus_wr_en && bus_addr && bus_wdata[0])) |=> err_tx);
    assert_rx_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rx && !(bus_wr_en && bus_addr && bus_wdata[1])) |=> err_rx);
    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= CNT_W'(DEPTH)) && (rx_level <= CNT_W'(DEPTH)));
    assert_drop_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && !bus_addr && tx_level == CNT_W'(DEPTH) && !eng_tx_req)
        |=> $stable(tx_level));
    assert_valid_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0) |-> !eng_tx_valid);
    assert_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en || bus_rd_en) |-> bus_ack);
endmodule

bind fifo_pair_status fps_checker #(.DEPTH(DEPTH), .CNT_W($clog2(DEPTH+1))) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .eng_tx_req(eng_tx_req), .eng_tx_valid(eng_tx_valid),
    .eng_rx_push(eng_rx_push), .tx_level(tx_level), .rx_level(rx_level),
    .err_tx(err_tx), .err_rx(err_rx)
);

// File: tb/fifo_pair_status_tb.sv
// Bench: a vector table walked by one loop, then directed corner tests.
module fifo_pair_status_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int NV = 10;
    // op[42:40] data[39:32] expected status[31:0]
    // op: 0 idle, 1 bus data write, 2 bus data read, 3 status write,
    //     4 engine pop, 5 engine push
    localparam logic [42:0] VEC [NV] = '{
        {3'd1, 8'hA1, 32'h0000_0120},
        {3'd1, 8'hB2, 32'h0000_0220},
        {3'd4, 8'h00, 32'h0000_0120},
        {3'd5, 8'h55, 32'h0001_0160},
        {3'd2, 8'h00, 32'h0000_0120},
        {3'd4, 8'h00, 32'h0000_0030},
        {3'd4, 8'h00, 32'h0000_0031},
        {3'd3, 8'h00, 32'h0000_0031},
        {3'd3, 8'h01, 32'h0000_0030},
        {3'd5, 8'h66, 32'h0001_0070}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr_en = 1'b0, bus_rd_en = 1'b0, bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_ack;
    logic eng_tx_req = 1'b0;
    logic [DW-1:0] eng_tx_data;
    logic eng_tx_valid;
    logic eng_rx_push = 1'b0;
    logic [DW-1:0] eng_rx_data = '0;
    logic eng_irq = 1'b0;
    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_pair_status #(.DATA_W(DW), .DEPTH(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .eng_tx_req(eng_tx_req), .eng_tx_data(eng_tx_data),
        .eng_tx_valid(eng_tx_valid), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_irq(eng_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operation for one clock edge.
    task automatic do_op(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        bus_wdata   = 32'(d);
        eng_rx_data = d;
        bus_wr_en   = (op == 3'd1) || (op == 3'd3);
        bus_rd_en   = (op == 3'd2);
        bus_addr    = (op == 3'd3);
        eng_tx_req  = (op == 3'd4);
        eng_rx_push = (op == 3'd5);
        @(negedge clk);
        bus_wr_en = 1'b0; bus_rd_en = 1'b0; bus_addr = 1'b0;
        eng_tx_req = 1'b0; eng_rx_push = 1'b0;
    endtask

    // Read the status word in the low phase; no clock edge passes.
    task automatic peek(input string req, input logic [31:0] exp);
        bus_rd_en = 1'b1; bus_addr = 1'b1;
        #1;
        check(req, bus_rdata, exp);
        bus_rd_en = 1'b0; bus_addr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        peek("R8 reset value", 32'h30);
        rst_n = 1'b1;
        peek("R8 after release", 32'h30);

        // Table walk: R1 R3 R5 R6 R7 R10
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][42:40], VEC[i][39:32]);
            peek("R5_R6_R7 vector", VEC[i][31:0]);
        end

        // R5 R7 fill the transmit queue to DEPTH
        for (int i = 0; i < 16; i++) do_op(3'd1, 8'(i));
        peek("R5 tx full", 32'h0001_1040);

        // R1 R10 overflow write: acknowledged, flagged
        @(negedge clk);
        bus_wr_en = 1'b1; bus_wdata = 32'hEE; #1;
        check("R10 ack on overflowed write", 32'(bus_ack), 32'd1);
        @(negedge clk);
        bus_wr_en = 1'b0;
        peek("R1 tx overflow flag", 32'h0001_1041);

        // R9 drain in order; the overflowed entry must be absent
        for (int i = 0; i < 16; i++) begin
            #1;
            check("R9 tx order", {23'd0, eng_tx_valid, eng_tx_data}, {23'd0, 1'b1, 8'(i)});
            do_op(3'd4, 8'h00);
        end
        #1;
        check("R9 tx valid low when empty", 32'(eng_tx_valid), 32'd0);
        peek("R5 tx empty again", 32'h0001_0071);
        do_op(3'd3, 8'h01);
        peek("R3 clear tx error", 32'h0001_0070);

        // R6 fill the receive queue (holds 0x66 already)
        for (int i = 1; i < 16; i++) do_op(3'd5, 8'(i));
        peek("R6 rx full", 32'h0010_00F0);
        do_op(3'd5, 8'hCC);
        peek("R2 rx overflow flag", 32'h0010_00F2);

        // R3 clear and new overflow in the same cycle: stays set
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h2;
        eng_rx_push = 1'b1; eng_rx_data = 8'hDD;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = 1'b0; eng_rx_push = 1'b0;
        peek("R3 set wins over clear", 32'h0010_00F2);
        do_op(3'd3, 8'h02);
        peek("R3 rx error cleared", 32'h0010_00F0);

        // R10 R9 drain receive queue over the bus in order
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            bus_rd_en = 1'b1; bus_addr = 1'b0; #1;
            check("R10 rx read data", bus_rdata, (i == 0) ? 32'h66 : 32'(i));
            @(negedge clk);
            bus_rd_en = 1'b0;
        end
        peek("R6 rx empty", 32'h30);
        @(negedge clk);
        bus_rd_en = 1'b1; #1;
        check("R10 empty read returns zero", bus_rdata, 32'h0);
        @(negedge clk);
        bus_rd_en = 1'b0;
        peek("R2 empty read raises no error", 32'h30);

        // R4 interrupt pass-through
        eng_irq = 1'b1;
        peek("R4 irq high", 32'h38);
        eng_irq = 1'b0;
        peek("R4 irq low", 32'h30);

        // R8 reset with state pending
        do_op(3'd1, 8'h11);
        do_op(3'd4, 8'h00);
        do_op(3'd4, 8'h00);
        do_op(3'd5, 8'h22);
        peek("R8 pre-reset state", 32'h0001_0071);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        peek("R8 reset clears state", 32'h30);

        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule